// File: doc/BRIEF.md
# Residual Timestamp Holding Queue

This block sits between the receive segmentation logic of one port and that port's clock-recovery PLL. It is a five-slot circular queue. Each slot holds a 4-bit residual timestamp nibble and an error flag. The receive side writes a 5-bit word on a strobe. The PLL asks for one word at a time. One cycle later it gets the nibble, a validity flag and a hold indication.

Every slot carries a live mark. A write sets the mark and a read clears it, so a slot that has been consumed reads back as stale. The read pointer keeps moving on every request, even when the queue has run dry. During a starvation spell the PLL therefore reads stale slots, and each one raises a one-cycle hold pulse that drives it into holdover. No empty handshake is needed.

An error-flagged word is also reported as not valid, so the PLL can discard it together with its local transmit-side partner. Running dry and overrunning the queue are recorded in two sticky status bits. A clear input resets both.

Top module: `resid_ts_fifo`

## Requirements
- R1: After reset every slot is stale and both pointers are at slot 0. `rd_ack`, `rd_valid`, `rd_stale`, `hold_pulse`, `underrun` and `overflow` are all 0.
- R2: A write with `wr_stb` stores `wr_word` at the write pointer and advances the pointer modulo 5. Reads return the words in the order they were written. `rd_ack` is high exactly in the cycle after a cycle with `rd_req`, and `rd_nib` then carries bits 3:0 of the word read.
- R3: `rd_valid` is 1 only in an acknowledged cycle whose slot was live and whose bit 4 was 0. In that cycle `hold_pulse` and `rd_stale` are 0.
- R4: A word with bit 4 = 1 is consumed like any other word. Its read gives `rd_valid` = 0, `hold_pulse` = 1 and `rd_stale` = 0.
- R5: Reading a slot clears its live mark. Reaching that slot again without an intervening write gives `rd_stale` = 1, `hold_pulse` = 1 and `rd_valid` = 0.
- R6: A read request that finds a stale slot sets the sticky `underrun` bit. The read pointer still advances by one slot.
- R7: A write without a read while all 5 slots are live sets the sticky `overflow` bit. The write overwrites the slot at the write pointer, and the read pointer moves to the slot after it. The next five reads return the four older words and then the new one.
- R8: A write and a read in the same cycle are both carried out. The read returns the slot's contents from before the write. When the queue is full, this does not set `overflow`.
- R9: `clr_status` clears `underrun` and `overflow` on the next edge. A status event in the same cycle takes priority, and its bit ends up set.
- R10: `hold_pulse` lasts one cycle for each bad read and is never high without `rd_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe from receive logic |
| wr_word | input | 5 | Bit 4 error flag, bits 3:0 timestamp nibble |
| rd_req | input | 1 | Read request from the PLL |
| clr_status | input | 1 | Clears both sticky status bits |
| rd_ack | output | 1 | Read result present this cycle |
| rd_nib | output | 4 | Timestamp nibble read |
| rd_valid | output | 1 | Read result usable |
| rd_stale | output | 1 | Read hit an already consumed slot |
| hold_pulse | output | 1 | One-cycle holdover request |
| underrun | output | 1 | Sticky: a read found a stale slot |
| overflow | output | 1 | Sticky: a write overran a full queue |

## Verification
The hardest state to reach is a read pointer that has run ahead of the write pointer. This happens when stale reads carry on past the last written word. A later write then lands behind the reader, and the reader must walk through several stale slots before it wraps round to the fresh one. The stimulus fills and drains all five slots, reads once more, writes a single word and then reads five times. It checks that four stale results come before the valid one. The full-queue cases are reached the same way, by filling all five slots and then applying either a lone write or a write paired with a read.

// File: rtl/rtsf_pkg.sv
package rtsf_pkg;
  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_GOOD  = 2'd1,
    RK_ERR   = 2'd2,
    RK_STALE = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/rtsf_store.sv
module rtsf_store #(
  parameter int DEPTH  = 5,
  parameter int WORD_W = 5,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word_q,
  output logic              rd_live_q,
  output logic              live_at_rd,
  output logic              full
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  live;

  // plain write port, no reset: maps to RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // registered read, read-before-write on a shared address
  always_ff @(posedge clk) begin
    if (rst)        rd_word_q <= '0;
    else if (rd_en) rd_word_q <= mem[rd_addr];
  end

  // live marks: a write sets, a read clears, a write wins a tie
  for (genvar i = 0; i < DEPTH; i++) begin : g_live
    always_ff @(posedge clk) begin
      if (rst)                                 live[i] <= 1'b0;
      else if (wr_en && wr_addr == AW'(i))     live[i] <= 1'b1;
      else if (rd_en && rd_addr == AW'(i))     live[i] <= 1'b0;
    end
  end

  assign live_at_rd = live[rd_addr];
  assign full       = &live;

  always_ff @(posedge clk) begin
    if (rst)        rd_live_q <= 1'b0;
    else if (rd_en) rd_live_q <= live_at_rd;
  end
endmodule

// File: rtl/rtsf_ptrs.sv
module rtsf_ptrs #(
  parameter int DEPTH = 5,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          full,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          ovf_evt
);
  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign ovf_evt = wr_en && !rd_en && full;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_en) wptr <= step(wptr);
      if (ovf_evt)    rptr <= step(wptr);
      else if (rd_en) rptr <= step(rptr);
    end
  end
endmodule

// File: rtl/rtsf_sticky.sv
module rtsf_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr)    q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/resid_ts_fifo.sv
module resid_ts_fifo
  import rtsf_pkg::*;
#(
  parameter int DEPTH  = 5,
  parameter int NIB_W  = 4,
  localparam int WORD_W = NIB_W + 1,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_req,
  input  logic              clr_status,
  output logic              rd_ack,
  output logic [NIB_W-1:0]  rd_nib,
  output logic              rd_valid,
  output logic              rd_stale,
  output logic              hold_pulse,
  output logic              underrun,
  output logic              overflow
);
  logic [AW-1:0]     wptr, rptr;
  logic              ovf_evt, full, live_at_rd, rd_live_q, ack_q;
  logic [WORD_W-1:0] rd_word_q;
  logic [1:0]        stat_q;
  rd_kind_e          kind;

  rtsf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_stb), .wr_addr(wptr), .wr_data(wr_word),
    .rd_en(rd_req), .rd_addr(rptr),
    .rd_word_q(rd_word_q), .rd_live_q(rd_live_q),
    .live_at_rd(live_at_rd), .full(full)
  );

  rtsf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst),
    .wr_en(wr_stb), .rd_en(rd_req), .full(full),
    .wptr(wptr), .rptr(rptr), .ovf_evt(ovf_evt)
  );

  // bit 0 underrun, bit 1 overflow
  rtsf_sticky #(.N(2)) u_stat (
    .clk(clk), .rst(rst),
    .set({ovf_evt, rd_req && !live_at_rd}),
    .clr(clr_status), .q(stat_q)
  );

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= rd_req;
  end

  always_comb begin
    if (!ack_q)                kind = RK_NONE;
    else if (!rd_live_q)       kind = RK_STALE;
    else if (rd_word_q[NIB_W]) kind = RK_ERR;
    else                       kind = RK_GOOD;
  end

  assign rd_ack     = ack_q;
  assign rd_nib     = rd_word_q[NIB_W-1:0];
  assign rd_valid   = (kind == RK_GOOD);
  assign rd_stale   = (kind == RK_STALE);
  assign hold_pulse = (kind == RK_STALE) || (kind == RK_ERR);
  assign underrun   = stat_q[0];
  assign overflow   = stat_q[1];
endmodule

// File: rtl/resid_ts_fifo_chk.sv
module resid_ts_fifo_chk (
  input logic clk,
  input logic rst,
  input logic rd_req,
  input logic clr_status,
  input logic rd_ack,
  input logic rd_valid,
  input logic rd_stale,
  input logic hold_pulse,
  input logic underrun,
  input logic overflow
);
  a_r2_ack_after_req: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_ack);
  a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
    rd_ack |-> $past(rd_req));
  a_r10_hold_needs_ack: assert property (@(posedge clk) disable iff (rst)
    hold_pulse |-> rd_ack);
  a_r3_valid_clean: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_ack && !hold_pulse && !rd_stale));
  a_r5_stale_holds: assert property (@(posedge clk) disable iff (rst)
    rd_stale |-> hold_pulse);
  a_r6_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (underrun && !clr_status) |=> underrun);
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (overflow && !clr_status) |=> overflow);
  a_r9_clear_falls: assert property (@(posedge clk) disable iff (rst)
    $fell(overflow) |-> $past(clr_status));
endmodule

bind resid_ts_fifo resid_ts_fifo_chk u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .clr_status(clr_status),
  .rd_ack(rd_ack), .rd_valid(rd_valid), .rd_stale(rd_stale),
  .hold_pulse(hold_pulse), .underrun(underrun), .overflow(overflow)
);

// File: tb/test_resid_ts_fifo.sv
module test_resid_ts_fifo;
  localparam int PERIOD = 10;

  logic       clk = 0, rst = 1, wr_stb = 0, rd_req = 0, clr_status = 0;
  logic [4:0] wr_word = '0;
  logic       rd_ack, rd_valid, rd_stale, hold_pulse, underrun, overflow;
  logic [3:0] rd_nib;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  resid_ts_fifo i_resid_ts_fifo (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_word(wr_word),
    .rd_req(rd_req), .clr_status(clr_status), .rd_ack(rd_ack),
    .rd_nib(rd_nib), .rd_valid(rd_valid), .rd_stale(rd_stale),
    .hold_pulse(hold_pulse), .underrun(underrun), .overflow(overflow)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle of stimulus; returns after the edge, away from it
  task automatic cyc(input bit w, input logic [4:0] d, input bit r, input bit c);
    wr_stb = w; wr_word = d; rd_req = r; clr_status = c;
    @(negedge clk);
    wr_stb = 0; rd_req = 0; clr_status = 0;
  endtask

  task automatic put(input logic [4:0] d);
    cyc(1, d, 0, 0);
  endtask

  task automatic get(input string tag, input int nib, input bit vld, input bit stl);
    cyc(0, '0, 1, 0);
    chk({tag, " ack"}, rd_ack, 1);
    chk({tag, " valid"}, rd_valid, vld);
    chk({tag, " stale"}, rd_stale, stl);
    chk({tag, " hold"}, hold_pulse, !vld);
    if (vld) chk({tag, " nib"}, rd_nib, nib);
  endtask

  task automatic do_reset();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ack", rd_ack, 0);
    chk("R1 valid", rd_valid, 0);
    chk("R1 hold", hold_pulse, 0);
    chk("R1 underrun", underrun, 0);
    chk("R1 overflow", overflow, 0);
    get("R1 first read stale", 0, 0, 1);
    cyc(0, '0, 0, 0);
    chk("R10 hold one cycle", hold_pulse, 0);
    chk("R10 ack drops", rd_ack, 0);
  endtask

  task automatic t_order();
    do_reset();
    put(5'h03); put(5'h0A); put(5'h0F);
    get("R2 first", 3, 1, 0);
    get("R2 second", 10, 1, 0);
    get("R3 third", 15, 1, 0);
    chk("R3 no underrun", underrun, 0);
  endtask

  task automatic t_error();
    do_reset();
    put(5'h17); put(5'h02);
    get("R4 flagged word", 7, 0, 0);
    get("R4 next word", 2, 1, 0);
    chk("R4 no underrun", underrun, 0);
  endtask

  task automatic t_runahead();
    do_reset();
    for (int i = 0; i < 5; i++) put(5'(i + 1));
    for (int i = 0; i < 5; i++) get("R5 drain", i + 1, 1, 0);
    chk("R6 not yet", underrun, 0);
    get("R5 reread slot0", 0, 0, 1);
    chk("R6 underrun set", underrun, 1);
    put(5'h07);
    for (int i = 0; i < 4; i++) get("R6 pointer past writer", 0, 0, 1);
    get("R6 wraps to fresh", 7, 1, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 5; i++) put(5'(i + 1));
    chk("R7 no overflow at full", overflow, 0);
    put(5'h06);
    chk("R7 overflow set", overflow, 1);
    for (int i = 0; i < 4; i++) get("R7 older words", i + 2, 1, 0);
    get("R7 newest word", 6, 1, 0);
    get("R7 then stale", 0, 0, 1);
    chk("R7 still sticky", overflow, 1);
  endtask

  task automatic t_simul();
    do_reset();
    for (int i = 0; i < 5; i++) put(5'(i + 1));
    cyc(1, 5'h09, 1, 0);
    chk("R8 read old", rd_nib, 1);
    chk("R8 read valid", rd_valid, 1);
    chk("R8 no overflow", overflow, 0);
    for (int i = 0; i < 4; i++) get("R8 rest", i + 2, 1, 0);
    get("R8 write kept", 9, 1, 0);
  endtask

  task automatic t_clear();
    do_reset();
    get("R9 make underrun", 0, 0, 1);
    chk("R9 underrun up", underrun, 1);
    cyc(0, '0, 0, 1);
    chk("R9 cleared", underrun, 0);
    cyc(0, '0, 1, 1);
    chk("R9 set wins", underrun, 1);
    for (int i = 0; i < 6; i++) put(5'(i));
    chk("R9 overflow up", overflow, 1);
    cyc(0, '0, 0, 1);
    chk("R9 overflow cleared", overflow, 0);
    chk("R9 underrun cleared", underrun, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_order();
    t_error();
    t_runahead();
    t_overflow();
    t_simul();
    t_clear();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule